// File: doc/BRIEF.md
# DS2 Off-Line Frame Aligner and Monitor

This block finds the M-frame alignment of a demultiplexed 6312 kbit/s DS2 serial stream and keeps watching it. Bits arrive one at a time on `din`, qualified by the clock enable `bit_en`. An active position counter marks the M-frame and subframe boundaries and checks the overhead bits. A separate hunt engine searches for a new alignment while the active alignment stays in use. The markers therefore keep their old phase until a new position is confirmed.

The M-frame is 4 subframes of 6 blocks. Each block is one overhead bit followed by BLK_LEN-1 payload bits (BLK_LEN defaults to 49, which gives 1176 bits per frame). The block checks the F and M overhead bits and reports far-end receive failure from the fourth M bit. It counts F-bit and M-bit errors in saturating counters. Error counting continues while out of frame. A latch strobe moves the counts into holding registers that stay readable until the next strobe.

Top module: `ds2_framer`

## Requirements
- R1: After reset, `oof`=1, `cofa`=0, `ferf`=0, `frame_mark`=0, `sub_mark`=0 and both held counts are 0.
- R2: Within each subframe of 6*BLK_LEN bits, the overhead bit sits at bit offset k*BLK_LEN of block k, in the order M, C1, F1, C2, C3, F2. F1 must be 0 and F2 must be 1. The M bits of subframes 0, 1, 2 must be 0, 1, 1. Given a stream in this format, the framer acquires alignment and clears `oof`.
- R3: Once aligned, `frame_mark` pulses for one clock right after the edge that takes bit 0 of subframe 0. `sub_mark` pulses in the same way after bit 0 of every subframe.
- R4: `oof` is set on the edge that takes an F bit when 2 or more of the last 4 F bits were in error. Two errored F bits that are 4 F bits apart do not set it.
- R5: While `oof` is high, the markers keep the previous alignment. If the same alignment is then found again, `oof` clears with no `cofa` pulse.
- R6: When the newly confirmed alignment differs from the active one, `cofa` pulses for exactly one clock as `oof` clears, and the markers follow the new alignment from then on.
- R7: The M bit of subframe 3 is the far-end receive failure bit, active low. While in frame, a 0 there sets `ferf` and a 1 clears it.
- R8: Every F bit that disagrees with its expected value adds one to the F-error count, including while `oof` is high.
- R9: An M bit of subframe 0, 1 or 2 that disagrees with 0, 1, 1 adds one to the M-error count. The M bit of subframe 3 is never counted as an error.
- R10: A `latch` pulse copies both counts into `f_err_cnt` and `m_err_cnt` and restarts counting from zero. Each count stops at 2^CNT_W-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High when `din` carries a new stream bit |
| din | input | 1 | Serial DS2 bit |
| latch | input | 1 | Copy error counts to holding registers and clear them |
| frame_mark | output | 1 | Pulse after the first bit of an M-frame |
| sub_mark | output | 1 | Pulse after the first bit of each subframe |
| oof | output | 1 | Out-of-frame status |
| cofa | output | 1 | Change-of-frame-alignment pulse |
| ferf | output | 1 | Far-end receive failure indication |
| f_err_cnt | output | CNT_W | Held F-bit error count |
| m_err_cnt | output | CNT_W | Held M-bit error count |

## Verification
The bench runs a short-block configuration and drives the stream with idle gaps between bits. It places F errors exactly 4 F bits apart and also in adjacent F bits. A design with the wrong window length would miss the loss of frame, or would declare it falsely. The bench forces a loss of frame on a stream that is still correctly aligned. A framer that searched in line, or that reported a change without comparing positions, would move the markers or raise `cofa` here. After a 5-bit slip, it expects exactly one `cofa`. It also pushes the M-error count past its maximum, so a wrapping counter would report a small number.

// File: rtl/ds2fr_pkg.sv
package ds2fr_pkg;
  localparam int SUBS = 4;
  localparam int BLKS = 6;
  typedef enum logic [1:0] {HUNT_IDLE, HUNT_F, HUNT_M} hunt_st_t;
endpackage

// File: rtl/ds2fr_track.sv
module ds2fr_track
  import ds2fr_pkg::*;
#(
  parameter int BLK_LEN = 49,
  parameter int F_WIN   = 4,
  parameter int F_LIM   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic din,
  input  logic hit,
  output logic oof,
  output logic cofa,
  output logic ferf,
  output logic frame_mark,
  output logic sub_mark,
  output logic f_err_ev,
  output logic m_err_ev
);
  localparam int SUB_LEN = BLKS * BLK_LEN;
  localparam int PW      = $clog2(SUB_LEN);
  localparam int F1_POS  = 2 * BLK_LEN;
  localparam int F2_POS  = 5 * BLK_LEN;

  logic [PW-1:0]    sub_pos;
  logic [1:0]       sub_idx;
  logic [F_WIN-1:0] fwin;
  logic [F_WIN-1:0] fwin_n;
  logic is_m, is_f1, is_f2, is_f, f_bad, m_bad, at_m3;

  always_comb begin
    is_m   = (sub_pos == '0);
    is_f1  = (sub_pos == PW'(F1_POS));
    is_f2  = (sub_pos == PW'(F2_POS));
    is_f   = is_f1 | is_f2;
    f_bad  = (is_f1 & din) | (is_f2 & ~din);
    m_bad  = is_m && (sub_idx != 2'(SUBS - 1)) && (din != (sub_idx != 2'd0));
    at_m3  = is_m && (sub_idx == 2'd2);
    fwin_n = {fwin[F_WIN-2:0], f_bad};
    f_err_ev = bit_en & f_bad;
    m_err_ev = bit_en & m_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_pos    <= '0;
      sub_idx    <= '0;
      fwin       <= '0;
      oof        <= 1'b1;
      cofa       <= 1'b0;
      ferf       <= 1'b0;
      frame_mark <= 1'b0;
      sub_mark   <= 1'b0;
    end else begin
      cofa       <= 1'b0;
      frame_mark <= 1'b0;
      sub_mark   <= 1'b0;
      if (bit_en) begin
        sub_mark   <= is_m;
        frame_mark <= is_m && (sub_idx == 2'd0);
        if (!oof && is_m && sub_idx == 2'(SUBS - 1))
          ferf <= ~din;
        if (hit) begin
          sub_pos <= PW'(1);
          sub_idx <= 2'd2;
          oof     <= 1'b0;
          fwin    <= '0;
          cofa    <= !at_m3;
        end else begin
          if (sub_pos == PW'(SUB_LEN - 1)) begin
            sub_pos <= '0;
            sub_idx <= sub_idx + 2'd1;
          end else begin
            sub_pos <= sub_pos + PW'(1);
          end
          if (is_f) begin
            fwin <= fwin_n;
            if (!oof && $countones(fwin_n) >= F_LIM)
              oof <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  cofa_oof_chk: assert property (@(posedge clk) disable iff (rst)
    cofa |-> ($past(oof) && !oof));
  // R3
  mark_nest_chk: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> sub_mark);
  // R4
  oof_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oof) |-> $past(f_err_ev));
  // R7
  ferf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> $stable(ferf));
endmodule

// File: rtl/ds2fr_hunt.sv
module ds2fr_hunt
  import ds2fr_pkg::*;
#(
  parameter int BLK_LEN   = 49,
  parameter int F_CONFIRM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic din,
  input  logic hunt,
  output logic hit
);
  localparam int SUB_LEN = BLKS * BLK_LEN;
  localparam int HALF    = 3 * BLK_LEN;
  localparam int PW      = $clog2(SUB_LEN);
  localparam int HW      = $clog2(HALF);
  localparam int RW      = $clog2(F_CONFIRM);
  localparam int F1_POS  = 2 * BLK_LEN;
  localparam int F2_POS  = 5 * BLK_LEN;

  hunt_st_t      st;
  logic [HW-1:0] h_cnt;
  logic [RW-1:0] f_run;
  logic [PW-1:0] sf_cnt;
  logic [2:0]    m_hist;
  logic [2:0]    m_cnt;
  logic          last_f, have_ref, f_fail;

  always_comb begin
    hit = bit_en && (st == HUNT_M) && (sf_cnt == '0) &&
          ({m_hist[1:0], din} == 3'b011) && (m_cnt >= 3'd2);
    f_fail = ((sf_cnt == PW'(F1_POS)) && din) || ((sf_cnt == PW'(F2_POS)) && !din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= HUNT_IDLE;
      h_cnt    <= '0;
      f_run    <= '0;
      sf_cnt   <= '0;
      m_hist   <= '0;
      m_cnt    <= '0;
      last_f   <= 1'b0;
      have_ref <= 1'b0;
    end else if (!hunt) begin
      st <= HUNT_IDLE;
    end else begin
      case (st)
        HUNT_IDLE: begin
          st       <= HUNT_F;
          h_cnt    <= '0;
          f_run    <= '0;
          have_ref <= 1'b0;
        end
        HUNT_F: if (bit_en) begin
          if (h_cnt == '0) begin
            if (!have_ref) begin
              last_f   <= din;
              have_ref <= 1'b1;
              f_run    <= '0;
              h_cnt    <= HW'(1);
            end else if (din == last_f) begin
              have_ref <= 1'b0;
            end else if (f_run == RW'(F_CONFIRM - 2)) begin
              st     <= HUNT_M;
              sf_cnt <= din ? PW'(F2_POS + 1) : PW'(F1_POS + 1);
              m_hist <= '0;
              m_cnt  <= '0;
            end else begin
              f_run  <= f_run + RW'(1);
              last_f <= din;
              h_cnt  <= HW'(1);
            end
          end else begin
            h_cnt <= (h_cnt == HW'(HALF - 1)) ? '0 : h_cnt + HW'(1);
          end
        end
        HUNT_M: if (bit_en) begin
          sf_cnt <= (sf_cnt == PW'(SUB_LEN - 1)) ? '0 : sf_cnt + PW'(1);
          if (hit) begin
            st <= HUNT_IDLE;
          end else if (f_fail) begin
            st       <= HUNT_F;
            h_cnt    <= '0;
            have_ref <= 1'b0;
          end else if (sf_cnt == '0) begin
            m_hist <= {m_hist[1:0], din};
            if (m_cnt == 3'd5) begin
              st       <= HUNT_F;
              h_cnt    <= '0;
              have_ref <= 1'b0;
            end else begin
              m_cnt <= m_cnt + 3'd1;
            end
          end
        end
        default: st <= HUNT_IDLE;
      endcase
    end
  end

  // R5
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hunt |-> !hit);
endmodule

// File: rtl/ds2fr_errcnt.sv
module ds2fr_errcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic         latch,
  output logic [W-1:0] hold
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt;
  logic         bump;

  always_comb bump = ev && (cnt != MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      hold <= '0;
    end else if (latch) begin
      hold <= bump ? cnt + W'(1) : cnt;
      cnt  <= '0;
    end else if (bump) begin
      cnt <= cnt + W'(1);
    end
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch && cnt == MAXV) |=> (cnt == MAXV));
  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(hold));
endmodule

// File: rtl/ds2_framer.sv
module ds2_framer #(
  parameter int BLK_LEN   = 49,
  parameter int CNT_W     = 16,
  parameter int F_CONFIRM = 8,
  parameter int F_WIN     = 4,
  parameter int F_LIM     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             din,
  input  logic             latch,
  output logic             frame_mark,
  output logic             sub_mark,
  output logic             oof,
  output logic             cofa,
  output logic             ferf,
  output logic [CNT_W-1:0] f_err_cnt,
  output logic [CNT_W-1:0] m_err_cnt
);
  logic             hit;
  logic [1:0]       ev;
  logic [CNT_W-1:0] held [2];

  ds2fr_track #(.BLK_LEN(BLK_LEN), .F_WIN(F_WIN), .F_LIM(F_LIM)) u_track (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .hit(hit),
    .oof(oof), .cofa(cofa), .ferf(ferf),
    .frame_mark(frame_mark), .sub_mark(sub_mark),
    .f_err_ev(ev[0]), .m_err_ev(ev[1])
  );

  ds2fr_hunt #(.BLK_LEN(BLK_LEN), .F_CONFIRM(F_CONFIRM)) u_hunt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .hunt(oof), .hit(hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    ds2fr_errcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .ev(ev[g]), .latch(latch), .hold(held[g])
    );
  end

  assign f_err_cnt = held[0];
  assign m_err_cnt = held[1];
endmodule

// File: tb/sim_ds2_framer.sv
module sim_ds2_framer;
  localparam int B    = 7;
  localparam int SUBL = 6 * B;
  localparam int FRL  = 4 * SUBL;
  localparam int CW   = 3;

  logic clk = 0, rst = 1, bit_en = 0, din = 0, latch = 0;
  logic frame_mark, sub_mark, oof, cofa, ferf;
  logic [CW-1:0] f_err_cnt, m_err_cnt;

  ds2_framer #(.BLK_LEN(B), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .latch(latch),
    .frame_mark(frame_mark), .sub_mark(sub_mark), .oof(oof), .cofa(cofa),
    .ferf(ferf), .f_err_cnt(f_err_cnt), .m_err_cnt(m_err_cnt)
  );

  always #2 clk = ~clk;

  int errs = 0, checks = 0, gen_pos = 0, nbits = 0, cofa_seen = 0, mk_bad = 0;
  bit mk_chk = 0, oof_seen = 0;
  logic [15:0] lf = 16'hACE1;
  logic oof_f [8];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic next_pay(output logic p);
    p  = lf[0];
    lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
  endtask

  function automatic logic exp_bit(int pos, logic m4, logic pay);
    int sp = pos % SUBL;
    int si = pos / SUBL;
    if (sp == 0) return (si == 0) ? 1'b0 : (si == 3) ? m4 : 1'b1;
    if (sp == 2 * B) return 1'b0;
    if (sp == 5 * B) return 1'b1;
    return pay;
  endfunction

  task automatic send_raw(logic b);
    nbits++;
    if (nbits % 4 == 0) begin
      @(negedge clk); bit_en = 0; din = ~b;
      @(posedge clk);
    end
    @(negedge clk); bit_en = 1; din = b;
    @(posedge clk); #1;
    if (cofa) cofa_seen++;
    if (oof) oof_seen = 1;
  endtask

  task automatic send_pos(logic flip, logic m4);
    logic p;
    next_pay(p);
    send_raw(exp_bit(gen_pos, m4, p) ^ flip);
    if (mk_chk && (frame_mark !== (gen_pos == 0) || sub_mark !== (gen_pos % SUBL == 0)))
      mk_bad++;
    gen_pos = (gen_pos + 1) % FRL;
  endtask

  task automatic run_frame(logic m4, logic [2:0] mflip, logic [7:0] fflip);
    for (int p = 0; p < FRL; p++) begin
      int sp = p % SUBL;
      int si = p / SUBL;
      logic fl = 1'b0;
      if (sp == 0 && si < 3) fl = mflip[si];
      if (sp == 2 * B) fl = fflip[2 * si];
      if (sp == 5 * B) fl = fflip[2 * si + 1];
      send_pos(fl, m4);
      if (sp == 2 * B) oof_f[2 * si] = oof;
      if (sp == 5 * B) oof_f[2 * si + 1] = oof;
    end
  endtask

  task automatic do_latch();
    @(negedge clk); bit_en = 0; latch = 1;
    @(negedge clk); latch = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(oof === 1'b1, "R1", "oof", oof, 1);
    chk(cofa === 1'b0 && ferf === 1'b0, "R1", "cofa|ferf", cofa | ferf, 0);
    chk(frame_mark === 1'b0 && sub_mark === 1'b0, "R1", "marks", frame_mark | sub_mark, 0);
    chk(f_err_cnt == 0 && m_err_cnt == 0, "R1", "held counts", f_err_cnt + m_err_cnt, 0);

    // R2 acquisition from an offset start, R6 first alignment differs
    gen_pos = 100;
    while (gen_pos != 0) send_pos(1'b0, 1'b1);
    k = 0;
    while (oof === 1'b1 && k < 60) begin run_frame(1'b1, 3'b0, 8'b0); k++; end
    chk(oof === 1'b0, "R2", "oof after acquire", oof, 0);
    chk(cofa_seen == 1, "R6", "cofa on first lock", cofa_seen, 1);
    do_latch();

    // R3 markers
    mk_chk = 1; mk_bad = 0;
    run_frame(1'b1, 3'b0, 8'b0);
    run_frame(1'b1, 3'b0, 8'b0);
    chk(mk_bad == 0, "R3", "marker mismatches", mk_bad, 0);

    // R7 far-end receive failure
    run_frame(1'b0, 3'b0, 8'b0);
    chk(ferf === 1'b1, "R7", "ferf set", ferf, 1);
    run_frame(1'b1, 3'b0, 8'b0);
    chk(ferf === 1'b0, "R7", "ferf clear", ferf, 0);
    do_latch();
    chk(m_err_cnt == 0, "R9", "M4 changes not counted", m_err_cnt, 0);

    // R9 M errors, R10 latch clear and saturation
    run_frame(1'b1, 3'b101, 8'b0);
    do_latch();
    chk(m_err_cnt == 2, "R9", "M errors", m_err_cnt, 2);
    chk(f_err_cnt == 0, "R8", "no F errors", f_err_cnt, 0);
    do_latch();
    chk(m_err_cnt == 0, "R10", "cleared after latch", m_err_cnt, 0);
    for (int i = 0; i < 3; i++) run_frame(1'b1, 3'b111, 8'b0);
    do_latch();
    chk(m_err_cnt == 7, "R10", "saturated count", m_err_cnt, 7);

    // R4 errors 4 F bits apart: no loss of frame
    run_frame(1'b1, 3'b0, 8'b0001_0001);
    chk(oof_f[4] === 1'b0 && oof === 1'b0, "R4", "spaced errors oof", oof_f[4] | oof, 0);
    do_latch();
    chk(f_err_cnt == 2, "R8", "F errors", f_err_cnt, 2);

    // R4 adjacent errors, R5 off-line hunt on intact stream, R8 count while oof
    cofa_seen = 0; mk_bad = 0;
    run_frame(1'b1, 3'b0, 8'b0000_0111);
    chk(oof_f[0] === 1'b0, "R4", "oof after one error", oof_f[0], 0);
    chk(oof_f[1] === 1'b1, "R4", "oof after second error", oof_f[1], 1);
    k = 0;
    while (oof === 1'b1 && k < 60) begin run_frame(1'b1, 3'b0, 8'b0); k++; end
    chk(oof === 1'b0, "R5", "relock same position", oof, 0);
    chk(cofa_seen == 0, "R5", "no cofa on same position", cofa_seen, 0);
    chk(mk_bad == 0, "R5", "markers kept while hunting", mk_bad, 0);
    do_latch();
    chk(f_err_cnt == 3, "R8", "F errors incl. while oof", f_err_cnt, 3);
    chk(m_err_cnt == 0, "R9", "no M errors", m_err_cnt, 0);

    // R6 slip of 5 bits
    mk_chk = 0;
    for (int i = 0; i < 5; i++) begin logic p; next_pay(p); send_raw(p); end
    cofa_seen = 0; oof_seen = 0; k = 0;
    while (!(oof_seen && oof === 1'b0) && k < 80) begin run_frame(1'b1, 3'b0, 8'b0); k++; end
    chk(oof === 1'b0 && oof_seen, "R6", "relock after slip", oof, 0);
    chk(cofa_seen == 1, "R6", "cofa after slip", cofa_seen, 1);
    mk_chk = 1; mk_bad = 0;
    run_frame(1'b1, 3'b0, 8'b0);
    chk(mk_bad == 0, "R6", "markers follow new position", mk_bad, 0);

    summary();
    $finish;
  end
endmodule